// File: doc/BRIEF.md
# Honeycomb Relative-Address Route Unit

This block decides, for one packet header, where a honeycomb router sends the packet next, and rewrites the header's relative address for that hop. The header carries two signed relative offsets, X and Y, each a 4-bit two's-complement field. Every node has a horizontal link on one side only, either east or west. Two static inputs describe the node: which side carries the horizontal link, and which vertical way a detour should take.

Horizontal progress always wins when this node's link points the way X needs to go. Otherwise the packet moves vertically toward its target row. If Y is already zero, the packet takes a one-step detour to a neighbouring row that has the right horizontal link, and the Y field then records the step back. A zero X and a zero Y send the packet to the local compute element. The local interface sits on whichever side has no horizontal neighbour.

The decision, the rewritten header and the payload are registered together, so the result appears one clock after the header is presented.

Top module: `rtu_route_unit`

## Requirements
- R1: While reset is held, and in the cycle after it is released, out_valid, out_dir and out_port are all zero.
- R2: out_valid equals in_valid from one clock earlier. While out_valid is low, out_dir and out_port are zero.
- R3: When X and Y are both zero, the logical direction is local (out_dir bit 4) and both address fields are passed on unchanged.
- R4: When X is positive and the horizontal link is on the east (link_east=1), the direction is east (out_dir bit 2) and X drops by 1. When X is negative and the link is on the west (link_east=0), the direction is west (out_dir bit 3) and X rises by 1. Y is unchanged in both cases.
- R5: When X is nonzero, the link points away from it, and Y is nonzero, the packet moves vertically: positive Y goes south (out_dir bit 1, Y minus 1), negative Y goes north (out_dir bit 0, Y plus 1). X is unchanged.
- R6: When X is nonzero, the link points away from it, and Y is zero, the packet detours. It goes north with Y set to +1 when detour_north=1, and south with Y set to -1 when detour_north=0. X is unchanged.
- R7: When X is zero and Y is nonzero, the packet moves vertically toward zero, using the same direction and update as R5.
- R8: out_port is one-hot over the physical sides (bit 0 north, 1 south, 2 east, 3 west). A neighbour direction maps to its own side. Local maps to west when link_east=1, and to east when link_east=0.
- R9: The payload appears on out_payload unchanged, in the same cycle as its route.
- R10: While out_valid is high, exactly one bit of out_dir is set. A non-local hop changes exactly one address field, by exactly one step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| link_east | input | 1 | Static: 1 = horizontal link on east side, 0 = on west side |
| detour_north | input | 1 | Static: 1 = Y-zero detour goes north, 0 = south |
| in_valid | input | 1 | Header present this cycle |
| in_x | input | AW (4) | Signed relative X offset |
| in_y | input | AW (4) | Signed relative Y offset |
| in_payload | input | PW (48) | Packet payload |
| out_valid | output | 1 | Registered route result valid |
| out_dir | output | 5 | One-hot logical direction: N, S, E, W, local |
| out_port | output | 4 | One-hot physical side: N, S, E, W |
| out_x | output | AW (4) | Rewritten X offset |
| out_y | output | AW (4) | Rewritten Y offset |
| out_payload | output | PW (48) | Forwarded payload |

## Verification
The bench sweeps all 256 (X, Y) pairs under each of the four combinations of link side and detour way. This sweep separates the horizontal-priority cases, the blocked-horizontal vertical moves, the Y-zero detours and the X-zero vertical moves. It also exercises the extreme values -8 and +7, where a wrong step direction would wrap. Because the link side changes between sweeps, a swapped mapping of east and west, or of the local port, shows up in the direction and port checks. Idle cycles and a reset in the middle of the run show that out_valid tracks in_valid and that the outputs go quiet.

// File: rtl/rtu_pkg.sv
// Shared types for the honeycomb route unit.
// Direction codes double as bit indices of the one-hot direction/port vectors.
package rtu_pkg;
    typedef enum logic [2:0] {
        DIR_N = 3'd0,
        DIR_S = 3'd1,
        DIR_E = 3'd2,
        DIR_W = 3'd3,
        DIR_L = 3'd4
    } rtu_dir_e;

    localparam int NUM_DIRS  = 5;
    localparam int NUM_PORTS = 4;
endpackage

// File: rtl/rtu_decide.sv
// Direction decision for one header.
// Assumes: X and Y are AW-bit two's-complement offsets; positive X is reached
// by stepping east, positive Y by stepping south. Purely combinational.
module rtu_decide
    import rtu_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic [AW-1:0] x,
    input  logic [AW-1:0] y,
    input  logic          link_east,
    input  logic          detour_north,
    output rtu_dir_e      dir
);
    logic x_zero, y_zero, x_pos, x_neg, y_neg;
    logic horiz_ok;

    // Classify the signs of both offsets.
    always_comb begin
        x_zero = (x == '0);
        y_zero = (y == '0);
        x_neg  = x[AW-1];
        x_pos  = !x_zero && !x_neg;
        y_neg  = y[AW-1];
    end

    // A horizontal hop is possible only toward the side that has the link.
    always_comb horiz_ok = (x_pos && link_east) || (x_neg && !link_east);

    // Priority: local, horizontal, vertical toward zero, then Y-zero detour.
    always_comb begin
        if (x_zero && y_zero)
            dir = DIR_L;
        else if (horiz_ok)
            dir = link_east ? DIR_E : DIR_W;
        else if (!y_zero)
            dir = y_neg ? DIR_N : DIR_S;
        else
            dir = detour_north ? DIR_N : DIR_S;
    end
endmodule

// File: rtl/rtu_rewrite.sv
// Next-hop address rewrite: N adds 1 to Y, S subtracts 1 from Y,
// W adds 1 to X, E subtracts 1 from X; local leaves both fields alone.
// Assumes the AW-bit arithmetic wraps naturally (the decision never needs it).
module rtu_rewrite
    import rtu_pkg::*;
#(
    parameter int AW = 4
) (
    input  rtu_dir_e      dir,
    input  logic [AW-1:0] x,
    input  logic [AW-1:0] y,
    output logic [AW-1:0] nx,
    output logic [AW-1:0] ny
);
    localparam logic [AW-1:0] ONE = AW'(1);

    // Apply the one-step update belonging to the chosen direction.
    always_comb begin
        nx = x;
        ny = y;
        unique case (dir)
            DIR_N:   ny = y + ONE;
            DIR_S:   ny = y - ONE;
            DIR_E:   nx = x - ONE;
            DIR_W:   nx = x + ONE;
            default: ;
        endcase
    end
endmodule

// File: rtl/rtu_portmap.sv
// Expands the direction code into a one-hot logical vector and a one-hot
// physical-side vector. Local goes to the side without a horizontal link.
module rtu_portmap
    import rtu_pkg::*;
(
    input  rtu_dir_e               dir,
    input  logic                   link_east,
    output logic [NUM_DIRS-1:0]    dir_oh,
    output logic [NUM_PORTS-1:0]   port_oh
);
    rtu_dir_e local_side;

    // The local interface occupies the free horizontal side.
    always_comb local_side = link_east ? DIR_W : DIR_E;

    for (genvar g = 0; g < NUM_DIRS; g++) begin : g_dir
        // One logical bit per direction code.
        assign dir_oh[g] = (dir == rtu_dir_e'(g));
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        // A side is used by its own direction or by local when it is free.
        assign port_oh[p] = dir_oh[p] || (dir_oh[DIR_L] && (local_side == rtu_dir_e'(p)));
    end
endmodule

// File: rtl/rtu_route_unit.sv
// Route unit of a honeycomb router: picks the next hop from the relative
// address and rewrites the address, registering the result for one cycle.
// Assumes link_east and detour_north are static per node.
module rtu_route_unit
    import rtu_pkg::*;
#(
    parameter int AW = 4,
    parameter int PW = 48
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 link_east,
    input  logic                 detour_north,
    input  logic                 in_valid,
    input  logic [AW-1:0]        in_x,
    input  logic [AW-1:0]        in_y,
    input  logic [PW-1:0]        in_payload,
    output logic                 out_valid,
    output logic [NUM_DIRS-1:0]  out_dir,
    output logic [NUM_PORTS-1:0] out_port,
    output logic [AW-1:0]        out_x,
    output logic [AW-1:0]        out_y,
    output logic [PW-1:0]        out_payload
);
    rtu_dir_e              dir_c;
    logic [AW-1:0]         nx_c, ny_c;
    logic [NUM_DIRS-1:0]   dir_oh_c;
    logic [NUM_PORTS-1:0]  port_oh_c;

    rtu_decide #(.AW(AW)) u_decide (
        .x            (in_x),
        .y            (in_y),
        .link_east    (link_east),
        .detour_north (detour_north),
        .dir          (dir_c)
    );

    rtu_rewrite #(.AW(AW)) u_rewrite (
        .dir (dir_c),
        .x   (in_x),
        .y   (in_y),
        .nx  (nx_c),
        .ny  (ny_c)
    );

    rtu_portmap u_portmap (
        .dir       (dir_c),
        .link_east (link_east),
        .dir_oh    (dir_oh_c),
        .port_oh   (port_oh_c)
    );

    // Output register: requests only while a header is valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_dir   <= '0;
            out_port  <= '0;
        end else begin
            out_valid <= in_valid;
            out_dir   <= in_valid ? dir_oh_c  : '0;
            out_port  <= in_valid ? port_oh_c : '0;
        end
    end

    // Header and payload register: data only, no reset needed.
    always_ff @(posedge clk) begin
        out_x       <= nx_c;
        out_y       <= ny_c;
        out_payload <= in_payload;
    end
endmodule

// File: rtl/rtu_route_unit_chk.sv
// Property checker for rtu_route_unit, attached by bind.
module rtu_route_unit_chk #(
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [AW-1:0] in_x,
    input logic [AW-1:0] in_y,
    input logic          out_valid,
    input logic [4:0]    out_dir,
    input logic [3:0]    out_port,
    input logic [AW-1:0] out_x,
    input logic [AW-1:0] out_y
);
    logic [AW-1:0] prev_x, prev_y;
    logic [AW-1:0] dx, dy;
    logic          unit_step;

    // Remember the header that produced the current output.
    always_ff @(posedge clk) begin
        prev_x <= in_x;
        prev_y <= in_y;
    end

    always_comb begin
        dx = out_x - prev_x;
        dy = out_y - prev_y;
        unit_step = ((dx == '0) && ((dy == AW'(1)) || (dy == '1))) ||
                    ((dy == '0) && ((dx == AW'(1)) || (dx == '1)));
    end

    AST_RESET_IDLE:   assert property (@(posedge clk) !rst_n |=> (!out_valid && out_dir == '0)); // R1
    AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R2
    AST_IDLE_QUIET:   assert property (@(posedge clk) disable iff (!rst_n) !out_valid |-> (out_dir == '0 && out_port == '0)); // R2
    AST_LOCAL_ZERO:   assert property (@(posedge clk) disable iff (!rst_n) (out_valid && out_dir[4]) |-> (out_x == '0 && out_y == '0)); // R3
    AST_PORT_ONE:     assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> ($countones(out_port) == 1)); // R8
    AST_DIR_ONE:      assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> ($countones(out_dir) == 1)); // R10
    AST_UNIT_STEP:    assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !out_dir[4]) |-> unit_step); // R10
endmodule

bind rtu_route_unit rtu_route_unit_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_x      (in_x),
    .in_y      (in_y),
    .out_valid (out_valid),
    .out_dir   (out_dir),
    .out_port  (out_port),
    .out_x     (out_x),
    .out_y     (out_y)
);

// File: tb/rtu_route_unit_tb.sv
module rtu_route_unit_tb;
    localparam int AW = 4;
    localparam int PW = 48;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          link_east = 1'b0;
    logic          detour_north = 1'b0;
    logic          in_valid = 1'b0;
    logic [AW-1:0] in_x = '0;
    logic [AW-1:0] in_y = '0;
    logic [PW-1:0] in_payload = '0;
    logic          out_valid;
    logic [4:0]    out_dir;
    logic [3:0]    out_port;
    logic [AW-1:0] out_x, out_y;
    logic [PW-1:0] out_payload;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    rtu_route_unit #(.AW(AW), .PW(PW)) u_dut (
        .clk(clk), .rst_n(rst_n), .link_east(link_east), .detour_north(detour_north),
        .in_valid(in_valid), .in_x(in_x), .in_y(in_y), .in_payload(in_payload),
        .out_valid(out_valid), .out_dir(out_dir), .out_port(out_port),
        .out_x(out_x), .out_y(out_y), .out_payload(out_payload)
    );

    // Direction indices of the bench's own model: 0 N, 1 S, 2 E, 3 W, 4 local.
    task automatic check_idle(input string tag);
        checks++;
        if (out_valid !== 1'b0 || out_dir !== 5'd0 || out_port !== 4'd0) begin
            errors++;
            $display("FAIL %s: valid=%b dir=%b port=%b, expected 0 0 0",
                     tag, out_valid, out_dir, out_port);
        end
    endtask

    task automatic run_vec(input int x, input int y, input bit le, input bit dn, input int idx);
        int d, nx, ny;
        string tag;
        logic [3:0] exp_port;
        logic [PW-1:0] pay;
        // Reference model from the requirements.
        nx = x; ny = y;
        if (x == 0 && y == 0) begin d = 4; tag = "R3"; end
        else if (x > 0 && le) begin d = 2; nx = x - 1; tag = "R4"; end
        else if (x < 0 && !le) begin d = 3; nx = x + 1; tag = "R4"; end
        else if (y != 0) begin
            if (y < 0) begin d = 0; ny = y + 1; end else begin d = 1; ny = y - 1; end
            tag = (x == 0) ? "R7" : "R5";
        end else begin
            if (dn) begin d = 0; ny = 1; end else begin d = 1; ny = -1; end
            tag = "R6";
        end
        exp_port = (d < 4) ? 4'(1 << d) : (le ? 4'b1000 : 4'b0100);
        pay = {16'(idx), ~32'(idx)};

        @(negedge clk);
        link_east = le; detour_north = dn;
        in_valid = 1'b1; in_x = AW'(x); in_y = AW'(y); in_payload = pay;
        @(negedge clk);

        checks++;
        if (out_valid !== 1'b1 || out_dir !== 5'(1 << d) || out_x !== AW'(nx) || out_y !== AW'(ny)) begin
            errors++;
            $display("FAIL %s/R2/R10: x=%0d y=%0d le=%0b dn=%0b got v=%b dir=%b x=%h y=%h exp v=1 dir=%b x=%h y=%h",
                     tag, x, y, le, dn, out_valid, out_dir, out_x, out_y, 5'(1 << d), AW'(nx), AW'(ny));
        end
        checks++;
        if (out_port !== exp_port) begin
            errors++;
            $display("FAIL R8: x=%0d y=%0d le=%0b got port=%b exp %b", x, y, le, out_port, exp_port);
        end
        checks++;
        if (out_payload !== pay) begin
            errors++;
            $display("FAIL R9: payload got %h exp %h", out_payload, pay);
        end
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int idx = 0;
        repeat (3) @(negedge clk);
        check_idle("R1 reset held");
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 after release");

        for (int le = 0; le < 2; le++) begin
            for (int dn = 0; dn < 2; dn++) begin
                for (int x = -8; x < 8; x++) begin
                    for (int y = -8; y < 8; y++) begin
                        run_vec(x, y, le[0], dn[0], idx);
                        idx++;
                    end
                end
                // Idle cycle: valid must drop and requests go quiet.
                in_valid = 1'b0;
                @(negedge clk);
                check_idle("R2 idle");
            end
        end

        // Reset during traffic.
        run_vec(3, -2, 1'b1, 1'b0, idx);
        rst_n = 1'b0; in_valid = 1'b1;
        @(negedge clk);
        check_idle("R1 mid-run reset");
        rst_n = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        check_idle("R2 after reset");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule